// File: doc/BRIEF.md
# Link keepalive generator and partner-loss monitor

This block keeps a point-to-point Ethernet link in use and notices when the far end has gone quiet. It takes one pulse per slot time (512 bit times) and a programmable period, counted in slot times. On the transmit side it counts slot times since the last outgoing frame. When half the period passes with nothing sent, it emits a keepalive frame. The frame is laid out as a MAC control frame and carries a programmable 16-bit opcode. It leaves the block as a byte stream with valid, ready and last.

On the receive side it counts slot times since the last good incoming frame. When a whole period passes without one, it raises a timeout interrupt. The interrupt stays set until software writes one to clear it. A period of zero turns off both functions. The MAC, the PHY, CRC insertion and register decoding all sit outside this block.

Top module: `link_keepalive`

## Requirements
- R1: After a synchronous reset, `hb_valid`, `hb_last` and `irq_timeout` are low.
- R2: With a nonzero period P, the transmit threshold is T = floor(P/2), raised to 1 when that is zero. The T-th consecutive `slot_tick` with no transmitted frame starts a keepalive frame, and `hb_valid` is high after that clock edge.
- R3: A `tx_frame_evt` pulse resets the transmit idle count to zero. When it falls in the same cycle as a `slot_tick`, the reset wins and that tick is not counted.
- R4: The frame bytes, in order, are: 01 80 C2 00 00 01; then `src_mac` with bits [47:40] first; then 88 08; then `opcode_cfg` high byte, then low byte; then zero bytes up to a total of 60.
- R5: `hb_last` is high only on byte 60 (index 59). After that byte is accepted, `hb_valid` is low in the next cycle.
- R6: While `hb_valid` is high and `hb_ready` is low, `hb_data`, `hb_last` and `hb_valid` hold their values.
- R7: While a frame is in progress, slot ticks start no further frame. When the last byte is accepted, the transmit idle count restarts from zero, so the next frame needs T new ticks.
- R8: The P-th consecutive `slot_tick` without `rx_good_evt` sets `irq_timeout` after that edge. An `rx_good_evt` pulse resets the receive count, and it wins over a tick in the same cycle.
- R9: `irq_timeout` stays set, even through received frames, until `irq_clear` is high for one cycle. If a timeout and a clear happen in the same cycle, the timeout wins.
- R10: With a period of zero, no keepalive frame starts and `irq_timeout` is never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_tick | input | 1 | One-cycle pulse per slot time |
| tx_frame_evt | input | 1 | Pulse for each frame transmitted by the MAC |
| rx_good_evt | input | 1 | Pulse for each good frame received |
| period_cfg | input | 8 | Timeout period in slot times, 0 = off |
| opcode_cfg | input | 16 | Opcode placed in the keepalive frame |
| src_mac | input | 48 | Source address placed in the frame |
| irq_clear | input | 1 | Write-one-to-clear for the interrupt |
| hb_ready | input | 1 | Downstream accepts a byte |
| hb_data | output | 8 | Frame byte |
| hb_valid | output | 1 | Frame byte valid |
| hb_last | output | 1 | Final byte of the frame |
| irq_timeout | output | 1 | Sticky receive timeout interrupt |

## Verification
The hardest case to reach from the ports is a slot-time boundary while a keepalive frame is stalled. It is also the only way to show that no second request is queued behind the first. The stimulus holds `hb_ready` low so the frame stays pending, and applies many slot ticks. It then drains the frame and checks two things: exactly one 60-byte frame is accepted, and one more tick is not enough to start another frame. Separate steps line up a tick with a restart strobe, and a timeout with a clear, in the same cycle to test which one wins.

// File: rtl/lk_pkg.sv
package lk_pkg;
  localparam int unsigned FRAME_BYTES = 60;
  localparam int unsigned IDX_W = $clog2(FRAME_BYTES);

  function automatic logic [7:0] frame_byte(input int unsigned idx,
                                            input logic [47:0] src,
                                            input logic [15:0] opc);
    logic [7:0] b;
    b = 8'h00;
    case (idx)
      0:  b = 8'h01;
      1:  b = 8'h80;
      2:  b = 8'hC2;
      3:  b = 8'h00;
      4:  b = 8'h00;
      5:  b = 8'h01;
      6:  b = src[47:40];
      7:  b = src[39:32];
      8:  b = src[31:24];
      9:  b = src[23:16];
      10: b = src[15:8];
      11: b = src[7:0];
      12: b = 8'h88;
      13: b = 8'h08;
      14: b = opc[15:8];
      15: b = opc[7:0];
      default: b = 8'h00;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/lk_idle_timer.sv
module lk_idle_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         restart,
  input  logic         hold,
  input  logic [W-1:0] limit,
  output logic         fire
);
  logic [W-1:0] cnt_q;
  logic [W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign fire = (limit != '0) && tick && !restart && !hold &&
                (cnt_inc >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst || restart || hold || limit == '0)
      cnt_q <= '0;
    else if (tick)
      cnt_q <= fire ? '0 : cnt_inc[W-1:0];
  end
endmodule

// File: rtl/lk_frame_gen.sv
module lk_frame_gen
  import lk_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [47:0] src,
  input  logic [15:0] opc,
  input  logic        ready,
  output logic [7:0]  data,
  output logic        valid,
  output logic        last,
  output logic        busy
);
  logic [IDX_W-1:0] idx_q;
  logic             accept;

  assign accept = valid && ready;
  assign busy   = valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      last  <= 1'b0;
      idx_q <= '0;
      data  <= '0;
    end else if (!valid) begin
      if (start) begin
        valid <= 1'b1;
        last  <= 1'b0;
        idx_q <= '0;
        data  <= frame_byte(0, src, opc);
      end
    end else if (accept) begin
      if (last) begin
        valid <= 1'b0;
        last  <= 1'b0;
        idx_q <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
        data  <= frame_byte(int'(idx_q) + 1, src, opc);
        last  <= (int'(idx_q) + 1 == FRAME_BYTES - 1);
      end
    end
  end
endmodule

// File: rtl/link_keepalive.sv
module link_keepalive #(
  parameter int PERIOD_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                slot_tick,
  input  logic                tx_frame_evt,
  input  logic                rx_good_evt,
  input  logic [PERIOD_W-1:0] period_cfg,
  input  logic [15:0]         opcode_cfg,
  input  logic [47:0]         src_mac,
  input  logic                irq_clear,
  input  logic                hb_ready,
  output logic [7:0]          hb_data,
  output logic                hb_valid,
  output logic                hb_last,
  output logic                irq_timeout
);
  logic [PERIOD_W-1:0] half_period;
  logic [PERIOD_W-1:0] tx_limit;
  logic                tx_fire, rx_fire, gen_busy;

  assign half_period = period_cfg >> 1;
  assign tx_limit = (period_cfg == '0) ? '0 :
                    (half_period == '0) ? PERIOD_W'(1) : half_period;

  lk_idle_timer #(.W(PERIOD_W)) tx_timer_i (
    .clk(clk), .rst(rst), .tick(slot_tick), .restart(tx_frame_evt),
    .hold(gen_busy), .limit(tx_limit), .fire(tx_fire)
  );

  lk_idle_timer #(.W(PERIOD_W)) rx_timer_i (
    .clk(clk), .rst(rst), .tick(slot_tick), .restart(rx_good_evt),
    .hold(1'b0), .limit(period_cfg), .fire(rx_fire)
  );

  lk_frame_gen gen_i (
    .clk(clk), .rst(rst), .start(tx_fire), .src(src_mac), .opc(opcode_cfg),
    .ready(hb_ready), .data(hb_data), .valid(hb_valid), .last(hb_last),
    .busy(gen_busy)
  );

  always_ff @(posedge clk) begin
    if (rst)
      irq_timeout <= 1'b0;
    else if (rx_fire)
      irq_timeout <= 1'b1;
    else if (irq_clear)
      irq_timeout <= 1'b0;
  end
endmodule

// File: rtl/link_keepalive_chk.sv
module link_keepalive_chk #(
  parameter int PERIOD_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                tx_frame_evt,
  input logic [PERIOD_W-1:0] period_cfg,
  input logic                irq_clear,
  input logic                hb_ready,
  input logic [7:0]          hb_data,
  input logic                hb_valid,
  input logic                hb_last,
  input logic                irq_timeout
);
  logic [6:0] beat_q;

  always_ff @(posedge clk) begin
    if (rst) beat_q <= '0;
    else if (hb_valid && hb_ready) beat_q <= hb_last ? 7'd0 : beat_q + 7'd1;
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    hb_valid && !hb_ready |=> hb_valid && $stable(hb_data) && $stable(hb_last)); // R6
  AST_LAST_DROP: assert property (@(posedge clk) disable iff (rst)
    hb_valid && hb_ready && hb_last |=> !hb_valid); // R5
  AST_LAST_POS: assert property (@(posedge clk) disable iff (rst)
    hb_valid |-> (hb_last == (beat_q == 7'd59))); // R5
  AST_TX_RESTART_WINS: assert property (@(posedge clk) disable iff (rst)
    !hb_valid && tx_frame_evt |=> !hb_valid); // R3
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    irq_timeout && !irq_clear |=> irq_timeout); // R9
  AST_ZERO_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
    period_cfg == '0 && !irq_timeout |=> !irq_timeout); // R10
  AST_ZERO_NO_FRAME: assert property (@(posedge clk) disable iff (rst)
    period_cfg == '0 && !hb_valid |=> !hb_valid); // R10
endmodule

bind link_keepalive link_keepalive_chk #(.PERIOD_W(PERIOD_W)) chk_i (
  .clk(clk), .rst(rst), .tx_frame_evt(tx_frame_evt), .period_cfg(period_cfg),
  .irq_clear(irq_clear), .hb_ready(hb_ready), .hb_data(hb_data),
  .hb_valid(hb_valid), .hb_last(hb_last), .irq_timeout(irq_timeout)
);

// File: tb/link_keepalive_tb_top.sv
`timescale 1ns/1ps
module link_keepalive_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic slot_tick = 1'b0, tx_frame_evt = 1'b0, rx_good_evt = 1'b0;
  logic [7:0] period_cfg = 8'd0;
  logic [15:0] opcode_cfg = 16'h0012;
  logic [47:0] src_mac = 48'h02A1B2C3D4E5;
  logic irq_clear = 1'b0, hb_ready = 1'b0;
  logic [7:0] hb_data;
  logic hb_valid, hb_last, irq_timeout;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  link_keepalive dut_i (
    .clk(clk), .rst(rst), .slot_tick(slot_tick), .tx_frame_evt(tx_frame_evt),
    .rx_good_evt(rx_good_evt), .period_cfg(period_cfg), .opcode_cfg(opcode_cfg),
    .src_mac(src_mac), .irq_clear(irq_clear), .hb_ready(hb_ready),
    .hb_data(hb_data), .hb_valid(hb_valid), .hb_last(hb_last),
    .irq_timeout(irq_timeout)
  );

  // {period, ticks, expected hb_valid, expected irq}
  localparam logic [17:0] VEC [11] = '{
    {8'd8,   8'd3,   1'b0, 1'b0},
    {8'd8,   8'd4,   1'b1, 1'b0},
    {8'd8,   8'd7,   1'b1, 1'b0},
    {8'd8,   8'd8,   1'b1, 1'b1},
    {8'd1,   8'd1,   1'b1, 1'b1},
    {8'd0,   8'd20,  1'b0, 1'b0},
    {8'd255, 8'd126, 1'b0, 1'b0},
    {8'd255, 8'd127, 1'b1, 1'b0},
    {8'd3,   8'd1,   1'b1, 1'b0},
    {8'd3,   8'd3,   1'b1, 1'b1},
    {8'd2,   8'd2,   1'b1, 1'b1}
  };

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      slot_tick = 1'b1;
      cyc();
    end
    slot_tick = 1'b0;
  endtask

  task automatic drain();
    hb_ready = 1'b1;
    for (int i = 0; i < 100 && hb_valid; i++) cyc();
    hb_ready = 1'b0;
  endtask

  task automatic restart_all(input logic [7:0] p);
    drain();
    period_cfg = p;
    tx_frame_evt = 1'b1; rx_good_evt = 1'b1; irq_clear = 1'b1;
    cyc();
    tx_frame_evt = 1'b0; rx_good_evt = 1'b0; irq_clear = 1'b0;
  endtask

  function automatic logic [7:0] exp_byte(input int i);
    logic [7:0] dst [6] = '{8'h01, 8'h80, 8'hC2, 8'h00, 8'h00, 8'h01};
    if (i < 6) return dst[i];
    if (i < 12) return src_mac[8*(11-i) +: 8];
    if (i == 12) return 8'h88;
    if (i == 13) return 8'h08;
    if (i == 14) return opcode_cfg[15:8];
    if (i == 15) return opcode_cfg[7:0];
    return 8'h00;
  endfunction

  // expects a frame already pending; mode 1 throttles ready
  task automatic read_frame(input int mode, input string tag);
    int got = 0, bad = 0, stall_bad = 0;
    logic pv = 1'b0, pr = 1'b0;
    logic [7:0] pd = 8'h00;
    logic rdy;
    for (int c = 0; c < 400 && got < 60; c++) begin
      rdy = (mode == 0) ? 1'b1 : (c % 3 != 2);
      hb_ready = rdy;
      if (pv && !pr && (!hb_valid || hb_data != pd)) stall_bad++;
      if (hb_valid) begin
        if (hb_data != exp_byte(got)) bad++;
        if (hb_last != (got == 59)) bad++;
        if (rdy) got++;
      end
      pv = hb_valid; pr = rdy; pd = hb_data;
      cyc();
    end
    hb_ready = 1'b0;
    check(bad == 0, {tag, " R4 R5 byte/last errors"}, bad, 0);
    check(got == 60, {tag, " R5 bytes accepted"}, got, 60);
    check(!hb_valid, {tag, " R5 valid after last"}, hb_valid, 0);
    if (mode == 1) check(stall_bad == 0, {tag, " R6 stall hold"}, stall_bad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual expired expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    // R1 reset state
    check(!hb_valid && !hb_last && !irq_timeout, "R1 reset outputs",
          {hb_valid, hb_last, irq_timeout}, 0);
    rst = 1'b0;
    cyc();

    // R2 R8 R10 table
    foreach (VEC[k]) begin
      restart_all(VEC[k][17:10]);
      ticks(int'(VEC[k][9:2]));
      check(hb_valid == VEC[k][1], $sformatf("R2 R10 vec%0d hb_valid", k), hb_valid, VEC[k][1]);
      check(irq_timeout == VEC[k][0], $sformatf("R8 R10 vec%0d irq", k), irq_timeout, VEC[k][0]);
    end

    // R4 R5 content with full throughput
    restart_all(8'd8);
    ticks(4);
    read_frame(0, "frameA");

    // R6 throttled, different opcode
    opcode_cfg = 16'hBEEF;
    restart_all(8'd8);
    ticks(4);
    read_frame(1, "frameB");
    opcode_cfg = 16'h0012;

    // R3 restart, including restart together with a tick
    restart_all(8'd8);
    ticks(3);
    slot_tick = 1'b1; tx_frame_evt = 1'b1;
    cyc();
    slot_tick = 1'b0; tx_frame_evt = 1'b0;
    ticks(3);
    check(!hb_valid, "R3 restart wins over tick", hb_valid, 0);
    ticks(1);
    check(hb_valid, "R3 frame after fresh count", hb_valid, 1);

    // R7 no second request while stalled; count restarts after frame
    restart_all(8'd4);
    ticks(2);
    check(hb_valid, "R7 first frame pending", hb_valid, 1);
    ticks(10);
    read_frame(0, "R7 single");
    ticks(1);
    check(!hb_valid, "R7 one tick after frame", hb_valid, 0);
    ticks(1);
    check(hb_valid, "R7 second frame after threshold", hb_valid, 1);

    // R8 receive restart, with tick in same cycle
    restart_all(8'd6);
    ticks(5);
    slot_tick = 1'b1; rx_good_evt = 1'b1;
    cyc();
    slot_tick = 1'b0; rx_good_evt = 1'b0;
    ticks(5);
    check(!irq_timeout, "R8 rx restart wins", irq_timeout, 0);
    ticks(1);
    check(irq_timeout, "R8 timeout after full period", irq_timeout, 1);

    // R9 sticky through rx frame, cleared by write-one
    rx_good_evt = 1'b1;
    cyc();
    rx_good_evt = 1'b0;
    cyc();
    check(irq_timeout, "R9 sticky through rx frame", irq_timeout, 1);
    irq_clear = 1'b1;
    cyc();
    irq_clear = 1'b0;
    check(!irq_timeout, "R9 cleared", irq_timeout, 0);

    // R9 set wins over clear
    restart_all(8'd6);
    ticks(5);
    slot_tick = 1'b1; irq_clear = 1'b1;
    cyc();
    slot_tick = 1'b0; irq_clear = 1'b0;
    check(irq_timeout, "R9 set wins over clear", irq_timeout, 1);

    // R10 zero period after counts built up
    restart_all(8'd10);
    ticks(3);
    period_cfg = 8'd0;
    ticks(30);
    check(!hb_valid && !irq_timeout, "R10 disabled", {hb_valid, irq_timeout}, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule